// File: doc/BRIEF.md
# ECC Error Event Logger

This block sits next to a single-error-correct, double-error-detect memory datapath and keeps a software-visible record of what the decoder reports. The decoder drives two one-cycle strobes, one for a corrected event and one for an uncorrected event. Both share one payload: the failing address, the 8-bit syndrome and the 64-bit data word. Each class has its own capture set, holding the address, a status word with the syndrome and the two data halves. Each class also has a pending flag and a repeat flag in an interrupt status word. The level interrupt is high while any of those four flags is set. Software clears flags by writing a mask to the acknowledge register.

The option register holds the ECC mode, a syndrome pattern and a force bit. While the force bit is set and ECC is on, the next memory write strobe leaves the block with its check bits XORed by the pattern. The force bit then clears itself. Software reaches all of this through a plain 32-bit register port with a write strobe, an address and a combinational read-data output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `wr_check_out` equals `wr_check_in`.
- R2: The option register at offset 0x00 holds the mode in bits [1:0], the force bit in bit 8 and the syndrome pattern in bits [23:16]. All other bits read back as zero.
- R3: Mode values 1 and 3 (bit 0 set) turn ECC on. With mode 0 or 2, event strobes change no flag and no capture, and no injection takes place, so the force bit stays set.
- R4: An event of a class whose pending flag is clear loads that class's capture set and sets its pending flag. The capture set holds the address, the status word (syndrome in bits [15:8]) and the data low and high halves. Uncorrected captures sit at 0x08/0x0C/0x10/0x14 and corrected captures at 0x18/0x1C/0x20/0x24. The status word at 0x28 carries the corrected pending flag in bit 3 and the uncorrected pending flag in bit 5.
- R5: An event of a class whose pending flag is already set leaves that class's capture set unchanged. It sets the repeat flag: bit 4 for corrected, bit 6 for uncorrected.
- R6: The two classes are independent. Both can be pending at once, each with its own captured address.
- R7: Writing a mask to offset 0x2C clears the status bits that are set in the mask. `irq` is high exactly when at least one of the four flags is set.
- R8: An event and an acknowledge of the same class in the same cycle leave the pending flag set.
- R9: With ECC on and the force bit set, `wr_check_out` equals `wr_check_in` XOR the pattern during a write strobe. The force bit then clears, the mode and pattern are kept, and later strobes pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ce_valid | input | 1 | Corrected-error event strobe |
| ue_valid | input | 1 | Uncorrected-error event strobe |
| evt_addr | input | 32 | Failing address of the event |
| evt_syndrome | input | 8 | Syndrome of the event |
| evt_data | input | 64 | Failing data word of the event |
| wr_strobe | input | 1 | Memory write in progress |
| wr_check_in | input | 8 | Check bits from the encoder |
| wr_check_out | output | 8 | Check bits toward memory, possibly corrupted |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take event strobes, the write strobe and register writes to be single-cycle pulses sampled on the rising edge. They also take an acknowledge and an event of the same class in one cycle as a legal case, not an error. The stimulus drives each pulse for exactly one cycle and holds the event payload steady while its strobe is high. It puts register writes to the option register in cycles apart from the write strobe, so a consumed force bit is never overwritten in the same cycle. It does place an acknowledge and an event together on purpose, to exercise the case where the event wins.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int ERR_AW  = 32;
    localparam int DATA_W  = 64;
    localparam int SYN_W   = 8;
    localparam int MODE_W  = 2;
    localparam int REG_DW  = 32;
    localparam int HALF_W  = DATA_W / 2;

    // Register byte offsets
    localparam int OFS_OPT      = 'h00;
    localparam int OFS_UE_ADDR  = 'h08;
    localparam int OFS_UE_STAT  = 'h0C;
    localparam int OFS_UE_DLO   = 'h10;
    localparam int OFS_UE_DHI   = 'h14;
    localparam int OFS_CE_ADDR  = 'h18;
    localparam int OFS_CE_STAT  = 'h1C;
    localparam int OFS_CE_DLO   = 'h20;
    localparam int OFS_CE_DHI   = 'h24;
    localparam int OFS_ISTAT    = 'h28;
    localparam int OFS_IACK     = 'h2C;

    // Interrupt status bit positions
    localparam int IS_CE_PEND = 3;
    localparam int IS_CE_REP  = 4;
    localparam int IS_UE_PEND = 5;
    localparam int IS_UE_REP  = 6;

    // Option register field positions
    localparam int OPT_FORCE_BIT = 8;
    localparam int OPT_SYN_LSB   = 16;

    typedef enum int {CLS_CE = 0, CLS_UE = 1} err_class_e;
    localparam int N_CLASS = 2;

    typedef struct packed {
        logic [ERR_AW-1:0] addr;
        logic [SYN_W-1:0]  syn;
        logic [DATA_W-1:0] data;
    } err_capture_t;

    function automatic logic mode_enabled(input logic [MODE_W-1:0] m);
        return m[0];
    endfunction

    function automatic logic [REG_DW-1:0] stat_word(input logic [SYN_W-1:0] s);
        return REG_DW'({s, 8'h00});
    endfunction

endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_log_pkg::*;
#(
    parameter int PEND_BIT = IS_CE_PEND,
    parameter int REP_BIT  = IS_CE_REP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              en,
    input  logic              ack_wr,
    input  logic [REG_DW-1:0] ack_mask,
    input  err_capture_t      evt_in,
    output err_capture_t      cap,
    output logic              pend,
    output logic              rep
);

    logic hit;
    assign hit = evt && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= '0;
            pend <= 1'b0;
            rep  <= 1'b0;
        end else begin
            if (hit && !pend)
                cap <= evt_in;
            // a new event outranks an acknowledge of the same flag
            if (hit)
                pend <= 1'b1;
            else if (ack_wr && ack_mask[PEND_BIT])
                pend <= 1'b0;
            if (hit && pend)
                rep <= 1'b1;
            else if (ack_wr && ack_mask[REP_BIT])
                rep <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_log_inject.sv
module ecc_log_inject
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              opt_wr,
    input  logic [REG_DW-1:0] opt_wdata,
    input  logic              wr_strobe,
    input  logic [SYN_W-1:0]  chk_in,
    output logic [SYN_W-1:0]  chk_out,
    output logic [MODE_W-1:0] mode,
    output logic              force_on,
    output logic [SYN_W-1:0]  pattern,
    output logic              ecc_on
);

    logic arm;

    assign ecc_on  = mode_enabled(mode);
    assign arm     = ecc_on && force_on;
    assign chk_out = arm ? (chk_in ^ pattern) : chk_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            force_on <= 1'b0;
            pattern  <= '0;
        end else if (opt_wr) begin
            mode     <= opt_wdata[MODE_W-1:0];
            force_on <= opt_wdata[OPT_FORCE_BIT];
            pattern  <= opt_wdata[OPT_SYN_LSB +: SYN_W];
        end else if (wr_strobe && arm) begin
            force_on <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              ce_valid,
    input  logic              ue_valid,
    input  logic [ERR_AW-1:0] evt_addr,
    input  logic [SYN_W-1:0]  evt_syndrome,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              wr_strobe,
    input  logic [SYN_W-1:0]  wr_check_in,
    output logic [SYN_W-1:0]  wr_check_out,
    output logic              irq
);

    logic              opt_wr, ack_wr, ecc_on, opt_force;
    logic [MODE_W-1:0] opt_mode;
    logic [SYN_W-1:0]  opt_syn;
    err_capture_t      evt_pack;
    err_capture_t      cap_v  [N_CLASS];
    logic [N_CLASS-1:0] pend_v, rep_v, evt_v;
    logic              ce_pend, ce_rep, ue_pend, ue_rep;

    assign opt_wr   = reg_wr && (reg_addr == REG_AW'(OFS_OPT));
    assign ack_wr   = reg_wr && (reg_addr == REG_AW'(OFS_IACK));
    assign evt_pack = '{addr: evt_addr, syn: evt_syndrome, data: evt_data};
    assign evt_v[CLS_CE] = ce_valid;
    assign evt_v[CLS_UE] = ue_valid;

    ecc_log_inject u_inj (
        .clk       (clk),
        .rst       (rst),
        .opt_wr    (opt_wr),
        .opt_wdata (reg_wdata),
        .wr_strobe (wr_strobe),
        .chk_in    (wr_check_in),
        .chk_out   (wr_check_out),
        .mode      (opt_mode),
        .force_on  (opt_force),
        .pattern   (opt_syn),
        .ecc_on    (ecc_on)
    );

    for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
        localparam int PB = (c == CLS_CE) ? IS_CE_PEND : IS_UE_PEND;
        localparam int RB = (c == CLS_CE) ? IS_CE_REP  : IS_UE_REP;
        ecc_log_capture #(.PEND_BIT(PB), .REP_BIT(RB)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_v[c]),
            .en       (ecc_on),
            .ack_wr   (ack_wr),
            .ack_mask (reg_wdata),
            .evt_in   (evt_pack),
            .cap      (cap_v[c]),
            .pend     (pend_v[c]),
            .rep      (rep_v[c])
        );
    end

    assign ce_pend = pend_v[CLS_CE];
    assign ce_rep  = rep_v[CLS_CE];
    assign ue_pend = pend_v[CLS_UE];
    assign ue_rep  = rep_v[CLS_UE];
    assign irq     = |{pend_v, rep_v};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(OFS_OPT):     reg_rdata = REG_DW'({opt_syn, 7'b0, opt_force, 6'b0, opt_mode});
            REG_AW'(OFS_UE_ADDR): reg_rdata = REG_DW'(cap_v[CLS_UE].addr);
            REG_AW'(OFS_UE_STAT): reg_rdata = stat_word(cap_v[CLS_UE].syn);
            REG_AW'(OFS_UE_DLO):  reg_rdata = REG_DW'(cap_v[CLS_UE].data[HALF_W-1:0]);
            REG_AW'(OFS_UE_DHI):  reg_rdata = REG_DW'(cap_v[CLS_UE].data[DATA_W-1:HALF_W]);
            REG_AW'(OFS_CE_ADDR): reg_rdata = REG_DW'(cap_v[CLS_CE].addr);
            REG_AW'(OFS_CE_STAT): reg_rdata = stat_word(cap_v[CLS_CE].syn);
            REG_AW'(OFS_CE_DLO):  reg_rdata = REG_DW'(cap_v[CLS_CE].data[HALF_W-1:0]);
            REG_AW'(OFS_CE_DHI):  reg_rdata = REG_DW'(cap_v[CLS_CE].data[DATA_W-1:HALF_W]);
            REG_AW'(OFS_ISTAT): begin
                reg_rdata[IS_CE_PEND] = ce_pend;
                reg_rdata[IS_CE_REP]  = ce_rep;
                reg_rdata[IS_UE_PEND] = ue_pend;
                reg_rdata[IS_UE_REP]  = ue_rep;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ce_valid,
    input logic             ue_valid,
    input logic             ecc_on,
    input logic             opt_force,
    input logic             opt_wr,
    input logic             wr_strobe,
    input logic [SYN_W-1:0] wr_check_in,
    input logic [SYN_W-1:0] wr_check_out,
    input logic             ce_pend,
    input logic             ce_rep,
    input logic             ue_pend,
    input logic             ue_rep,
    input logic             irq
);

    a_r4_ce_event_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && ecc_on) |=> ce_pend);

    a_r8_ue_event_beats_ack: assert property (@(posedge clk) disable iff (rst)
        (ue_valid && ecc_on) |=> ue_pend);

    a_r5_ce_second_sets_repeat: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && ecc_on && ce_pend) |=> ce_rep);

    a_r5_ue_second_sets_repeat: assert property (@(posedge clk) disable iff (rst)
        (ue_valid && ecc_on && ue_pend) |=> ue_rep);

    a_r7_event_raises_irq: assert property (@(posedge clk) disable iff (rst)
        ((ce_valid || ue_valid) && ecc_on) |=> irq);

    a_r3_off_no_injection: assert property (@(posedge clk) disable iff (rst)
        !ecc_on |-> (wr_check_out == wr_check_in));

    a_r3_off_no_new_pending: assert property (@(posedge clk) disable iff (rst)
        (!ecc_on && !ce_pend && !ue_pend) |=> (!ce_pend && !ue_pend));

    a_r9_force_self_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && opt_force && ecc_on && !opt_wr) |=> !opt_force);

endmodule

bind ecc_err_log ecc_err_log_chk u_chk (.*);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
    import ecc_log_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              ce_valid = 1'b0, ue_valid = 1'b0;
    logic [31:0]       evt_addr = '0;
    logic [7:0]        evt_syndrome = '0;
    logic [63:0]       evt_data = '0;
    logic              wr_strobe = 1'b0;
    logic [7:0]        wr_check_in = '0;
    logic [7:0]        wr_check_out;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ecc_err_log dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int          m_mode, m_force, m_syn;
    int unsigned m_addr[2];
    int          m_esyn[2];
    logic [63:0] m_data[2];
    bit          m_pend[2], m_rep[2];

    function automatic int unsigned model_read(int a);
        case (a)
            'h00: return (m_syn << 16) | (m_force << 8) | m_mode;
            'h08: return m_addr[1];
            'h0C: return m_esyn[1] << 8;
            'h10: return m_data[1][31:0];
            'h14: return m_data[1][63:32];
            'h18: return m_addr[0];
            'h1C: return m_esyn[0] << 8;
            'h20: return m_data[0][31:0];
            'h24: return m_data[0][63:32];
            'h28: return (m_pend[0] << 3) | (m_rep[0] << 4) | (m_pend[1] << 5) | (m_rep[1] << 6);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_force = 0; m_syn = 0;
            for (int c = 0; c < 2; c++) begin
                m_addr[c] = 0; m_esyn[c] = 0; m_data[c] = '0;
                m_pend[c] = 0; m_rep[c] = 0;
            end
        end else begin
            bit on;
            bit ack;
            on  = (m_mode % 2) == 1;
            ack = reg_wr && reg_addr == 8'h2C;
            for (int c = 0; c < 2; c++) begin
                bit ev;
                bit was;
                int pb;
                ev  = on && ((c == 0) ? ce_valid : ue_valid);
                was = m_pend[c];
                pb  = (c == 0) ? 3 : 5;
                if (ev && !was) begin
                    m_addr[c] = evt_addr; m_esyn[c] = evt_syndrome; m_data[c] = evt_data;
                end
                if (ack && reg_wdata[pb]) m_pend[c] = 0;
                if (ack && reg_wdata[pb+1]) m_rep[c] = 0;
                if (ev) m_pend[c] = 1;
                if (ev && was) m_rep[c] = 1;
            end
            if (reg_wr && reg_addr == 8'h00) begin
                m_mode = reg_wdata[1:0]; m_force = reg_wdata[8]; m_syn = reg_wdata[23:16];
            end else if (wr_strobe && on && m_force == 1) begin
                m_force = 0;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the free-running outputs
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst && !done) begin
            bit any;
            bit inj;
            any = m_pend[0] || m_rep[0] || m_pend[1] || m_rep[1];
            check("R7 irq", irq, any);
            inj = (m_mode % 2 == 1) && m_force == 1;
            check("R9 wr_check_out", wr_check_out, inj ? (wr_check_in ^ 8'(m_syn)) : wr_check_in);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic rd(input int a, input string tag);
        @(negedge clk);
        reg_addr = 8'(a);
        #(CLK_PERIOD/4 + 1);
        check(tag, reg_rdata, model_read(a));
    endtask

    task automatic bus_wr(input int a, input int unsigned d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic event_pulse(input bit ce, input bit ue, input int unsigned a,
                               input int s, input logic [63:0] d,
                               input bit ack, input int unsigned mask);
        @(negedge clk);
        ce_valid = ce; ue_valid = ue;
        evt_addr = a; evt_syndrome = 8'(s); evt_data = d;
        reg_wr = ack; reg_addr = 8'h2C; reg_wdata = mask;
        @(negedge clk);
        ce_valid = 0; ue_valid = 0; reg_wr = 0;
    endtask

    task automatic strobe(input int chk);
        @(negedge clk);
        wr_strobe = 1; wr_check_in = 8'(chk);
        @(negedge clk);
        wr_strobe = 0;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a <= 'h28; a += 4) rd(a, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        read_all("R1 reset value");
        check("R1 irq after reset", irq, 0);
        strobe('h5C);

        // R2: option fields, unused bits read zero
        bus_wr('h00, 32'hFFFF_FFFE);
        rd('h00, "R2 option readback");
        @(negedge clk); reg_addr = 8'h00; #1;
        check("R2 option masked", reg_rdata, 32'h00FF_0102);

        // R3: disabled mode 2 ignores events and injection
        bus_wr('h00, 32'h00A5_0102);
        event_pulse(1, 1, 32'h1111_0000, 'h11, 64'h1, 0, 0);
        rd('h28, "R3 status untouched when off");
        rd('h18, "R3 capture untouched when off");
        strobe('h0F);
        rd('h00, "R3 force kept when off");

        // R9: one-shot injection in mode 1
        bus_wr('h00, 32'h005A_0101);
        strobe('h33);
        rd('h00, "R9 force cleared, fields kept");
        strobe('h33);

        // R4: first corrected event captures
        event_pulse(1, 0, 32'h1000_0040, 'h3C, 64'hDEAD_BEEF_0123_4567, 0, 0);
        read_all("R4 corrected capture");
        @(negedge clk); reg_addr = 8'h28; #1;
        check("R4 status bit3", reg_rdata, 32'h08);

        // R6: uncorrected alongside corrected
        event_pulse(0, 1, 32'h2000_0080, 'hC3, 64'hCAFE_F00D_89AB_CDEF, 0, 0);
        read_all("R6 both classes pending");

        // R5: second corrected keeps capture, sets repeat
        event_pulse(1, 0, 32'h3000_00C0, 'h77, 64'h5555_AAAA_5555_AAAA, 0, 0);
        read_all("R5 repeat corrected");

        // R7: acknowledge by mask
        bus_wr('h2C, 32'h08);
        rd('h28, "R7 ack pending only");
        bus_wr('h2C, 32'h10);
        rd('h28, "R7 ack repeat");

        // R8: event and acknowledge of the uncorrected class together
        event_pulse(0, 1, 32'h4000_0100, 'h99, 64'h1234, 1, 32'h60);
        read_all("R8 event beats ack");

        // R7: clear everything, irq falls
        bus_wr('h2C, 32'h78);
        rd('h28, "R7 all cleared");
        check("R7 irq low", irq, 0);

        // R4: fresh capture after clear
        event_pulse(0, 1, 32'h5000_0140, 'h42, 64'hFEDC_BA98_7654_3210, 0, 0);
        read_all("R4 fresh uncorrected capture");

        // R3: mode 3 also enables checking; both strobes at once
        bus_wr('h2C, 32'h78);
        bus_wr('h00, 32'h0081_0103);
        event_pulse(1, 1, 32'h6000_0180, 'h0E, 64'h0F0F_0F0F_F0F0_F0F0, 0, 0);
        read_all("R3 mode 3 enabled");
        strobe('hFF);
        rd('h00, "R3 mode 3 injection consumed");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule